// File: doc/BRIEF.md
# UART Register Front End

This block is the processor-facing register layer of a serial port. A simple bus with a one-bit address, separate write and read strobes and a data byte reaches two locations. Address 0 holds two separate registers: writes go to a transmit holding buffer and reads return the receive holding buffer. Address 1 is a status byte that reports receive complete, transmit complete, holding-buffer empty, framing error and overrun. Bit timing is handled elsewhere. The transmit engine takes a one-cycle start pulse with a byte and answers with a one-cycle done pulse once the stop bit has left. The receive engine delivers a one-cycle valid pulse with a byte and a stop-bit-good flag.

Two state machines do the work. The transmit sequencer has the states TX_IDLE and TX_SHIFT. TX_IDLE goes to TX_SHIFT when the holding buffer is full, and issues a start pulse on that move. TX_SHIFT stays in TX_SHIFT on a done pulse while the buffer is full, relaunching at once. It returns to TX_IDLE on a done pulse with no pending byte, and sets transmit complete on that move. The receive holder has the states RX_EMPTY and RX_HELD. RX_EMPTY goes to RX_HELD on a valid pulse. RX_HELD stays in RX_HELD when a read and a new byte arrive together, or when a byte arrives unread (overrun). It returns to RX_EMPTY on a read with no new byte.

Three interrupt requests are each gated by their own enable input. These are receive complete, transmit complete and holding-buffer empty. Transmit complete is also cleared by a vector acknowledge input.

Top module: `uart_reg_front`

## Requirements
- R1: After reset the status byte (address 1) reads 0x20, the receive data (address 0) reads 0x00, and no start pulse is issued.
- R2: A write to address 0 loads the transmit holding buffer and clears the empty flag, status bit 5, from the next cycle.
- R3: With the shifter idle, the start pulse carrying the buffered byte is issued in the cycle after the write edge. Bit 5 reads 1 again from the following cycle.
- R4: A byte written while a character is shifting is held with bit 5 at 0. Its start pulse is issued in the same cycle as the done pulse of the current character.
- R5: Transmit complete, status bit 6, sets after a done pulse only if no byte is pending. If a byte is pending it stays 0.
- R6: Bit 6 clears on a write to address 1 with bit 6 at 1, or on the acknowledge input. A write with bit 6 at 0 leaves it set. All other status bits ignore writes.
- R7: A receive valid pulse loads the receive buffer and sets receive complete, status bit 7. It also sets framing error, status bit 4, to the inverse of the stop-bit-good input, so a bad stop bit still sets bit 7.
- R8: A read strobe at address 0 returns the receive buffer, and clears bit 7 and the overrun bit after that edge.
- R9: A receive valid pulse while bit 7 is set and no read is taken at that edge discards the byte and sets overrun, status bit 3.
- R10: Each interrupt request equals its flag ANDed with its enable: receive with bit 7, transmit complete with bit 6, empty with bit 5.
- R11: Status bits 2 to 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 1 | 0 = data, 1 = status |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (side effects at address 0) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from address |
| rx_valid | input | 1 | Receive engine byte-complete pulse |
| rx_byte | input | DATA_W | Received byte |
| rx_stop_ok | input | 1 | Stop bit sampled as 1 |
| tx_start | output | 1 | Start pulse to transmit engine |
| tx_byte | output | DATA_W | Byte carried by the start pulse |
| tx_done | input | 1 | Stop bit shifted out pulse |
| ie_rx | input | 1 | Receive interrupt enable |
| ie_txc | input | 1 | Transmit complete interrupt enable |
| ie_empty | input | 1 | Empty interrupt enable |
| txc_ack | input | 1 | Transmit complete vector acknowledge |
| irq_rx | output | 1 | Receive interrupt request |
| irq_txc | output | 1 | Transmit complete interrupt request |
| irq_empty | output | 1 | Empty interrupt request |

## Verification
The bench builds the block with DATA_W at its default of 8, which puts the status flags at bits 7 to 3, as the requirements state. At this width the byte patterns 0xA5, 0x3C and 0x5A make each flag bit distinct from the data. A write of 0xFF to the status address reaches every read-only bit together. Overrun and back-to-back transmit relaunch are also reachable at this width.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
    typedef enum logic {TX_IDLE = 1'b0, TX_SHIFT = 1'b1} tx_state_e;
    typedef enum logic {RX_EMPTY = 1'b0, RX_HELD = 1'b1} rx_state_e;
endpackage

// File: rtl/uart_tx_seq.sv
module uart_tx_seq
    import uart_reg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tx_done,
    input  logic              txc_clr,
    output logic              tx_start,
    output logic [DATA_W-1:0] tx_byte,
    output logic              empty,
    output logic              txc
);
    tx_state_e         state_q, state_d;
    logic [DATA_W-1:0] hold_q;
    logic              full_q;
    logic              launch;
    logic              finish;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        launch  = 1'b0;
        finish  = 1'b0;
        unique case (state_q)
            TX_IDLE: begin
                if (full_q) begin
                    launch  = 1'b1;
                    state_d = TX_SHIFT;
                end
            end
            TX_SHIFT: begin
                if (tx_done) begin
                    if (full_q) begin
                        launch = 1'b1;
                    end else begin
                        state_d = TX_IDLE;
                        finish  = !data_wr;
                    end
                end
            end
            default: state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            full_q <= 1'b0;
            txc    <= 1'b0;
        end else begin
            if (data_wr)     hold_q <= wdata;
            if (data_wr)     full_q <= 1'b1;
            else if (launch) full_q <= 1'b0;
            if (finish)       txc <= 1'b1;
            else if (txc_clr) txc <= 1'b0;
        end
    end

    assign tx_start = launch;
    assign tx_byte  = hold_q;
    assign empty    = !full_q;
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
    import uart_reg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_stop_ok,
    input  logic              data_rd,
    output logic [DATA_W-1:0] rx_buf,
    output logic              rxc,
    output logic              fe,
    output logic              ovr
);
    rx_state_e state_q, state_d;
    logic      capture;
    logic      lost;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        lost    = 1'b0;
        unique case (state_q)
            RX_EMPTY: begin
                if (rx_valid) begin
                    capture = 1'b1;
                    state_d = RX_HELD;
                end
            end
            RX_HELD: begin
                if (data_rd) begin
                    capture = rx_valid;
                    if (!rx_valid) state_d = RX_EMPTY;
                end else if (rx_valid) begin
                    lost = 1'b1;
                end
            end
            default: state_d = RX_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_buf <= '0;
            fe     <= 1'b0;
            ovr    <= 1'b0;
        end else begin
            if (capture) begin
                rx_buf <= rx_byte;
                fe     <= !rx_stop_ok;
            end
            if (lost)         ovr <= 1'b1;
            else if (data_rd) ovr <= 1'b0;
        end
    end

    assign rxc = (state_q == RX_HELD);
endmodule

// File: rtl/uart_reg_front.sv
module uart_reg_front #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_stop_ok,
    output logic              tx_start,
    output logic [DATA_W-1:0] tx_byte,
    input  logic              tx_done,
    input  logic              ie_rx,
    input  logic              ie_txc,
    input  logic              ie_empty,
    input  logic              txc_ack,
    output logic              irq_rx,
    output logic              irq_txc,
    output logic              irq_empty
);
    localparam int RXC_BIT   = DATA_W - 1;
    localparam int TXC_BIT   = DATA_W - 2;
    localparam int EMPTY_BIT = DATA_W - 3;
    localparam int FE_BIT    = DATA_W - 4;
    localparam int OVR_BIT   = DATA_W - 5;

    logic              data_wr, data_rd, stat_wr, txc_clr;
    logic              empty, txc, rxc, fe, ovr;
    logic [DATA_W-1:0] rxbuf_w;
    logic [DATA_W-1:0] status_w;

    assign data_wr = reg_wr && !reg_addr;
    assign data_rd = reg_rd && !reg_addr;
    assign stat_wr = reg_wr && reg_addr;
    assign txc_clr = txc_ack || (stat_wr && reg_wdata[TXC_BIT]);

    uart_tx_seq #(.DATA_W(DATA_W)) tx_i (
        .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .wdata(reg_wdata),
        .tx_done(tx_done), .txc_clr(txc_clr), .tx_start(tx_start),
        .tx_byte(tx_byte), .empty(empty), .txc(txc)
    );

    uart_rx_hold #(.DATA_W(DATA_W)) rx_i (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_stop_ok(rx_stop_ok), .data_rd(data_rd), .rx_buf(rxbuf_w),
        .rxc(rxc), .fe(fe), .ovr(ovr)
    );

    always_comb begin
        status_w            = '0;
        status_w[RXC_BIT]   = rxc;
        status_w[TXC_BIT]   = txc;
        status_w[EMPTY_BIT] = empty;
        status_w[FE_BIT]    = fe;
        status_w[OVR_BIT]   = ovr;
    end

    assign reg_rdata = reg_addr ? status_w : rxbuf_w;
    assign irq_rx    = rxc && ie_rx;
    assign irq_txc   = txc && ie_txc;
    assign irq_empty = empty && ie_empty;
endmodule

// File: rtl/uart_reg_front_chk.sv
module uart_reg_front_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_byte,
    input logic              txc_ack,
    input logic              tx_start,
    input logic              ie_rx,
    input logic              irq_rx,
    input logic [DATA_W-1:0] status,
    input logic [DATA_W-1:0] rx_buf
);
    localparam int RXC_BIT   = DATA_W - 1;
    localparam int TXC_BIT   = DATA_W - 2;
    localparam int EMPTY_BIT = DATA_W - 3;
    localparam int OVR_BIT   = DATA_W - 5;

    // R2
    empty_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_addr) |=> !status[EMPTY_BIT]);

    // R3
    start_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> !status[EMPTY_BIT]);

    // R7
    rx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !status[RXC_BIT]) |=> (status[RXC_BIT] && rx_buf == $past(rx_byte)));

    // R9
    overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && status[RXC_BIT] && !(reg_rd && !reg_addr)) |=> (status[OVR_BIT] && $stable(rx_buf)));

    // R6
    txc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[TXC_BIT] && !txc_ack && !(reg_wr && reg_addr && reg_wdata[TXC_BIT])) |=> status[TXC_BIT]);

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_rx |-> !irq_rx);
endmodule

bind uart_reg_front uart_reg_front_chk #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .txc_ack(txc_ack), .tx_start(tx_start),
    .ie_rx(ie_rx), .irq_rx(irq_rx), .status(status_w), .rx_buf(rxbuf_w)
);

// File: tb/uart_reg_front_test.sv
module uart_reg_front_test;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_addr = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              rx_valid = 1'b0, rx_stop_ok = 1'b1;
    logic [DATA_W-1:0] rx_byte = '0;
    logic              tx_start, tx_done = 1'b0;
    logic [DATA_W-1:0] tx_byte;
    logic              ie_rx = 1'b1, ie_txc = 1'b1, ie_empty = 1'b1, txc_ack = 1'b0;
    logic              irq_rx, irq_txc, irq_empty;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    uart_reg_front #(.DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_stop_ok(rx_stop_ok),
        .tx_start(tx_start), .tx_byte(tx_byte), .tx_done(tx_done),
        .ie_rx(ie_rx), .ie_txc(ie_txc), .ie_empty(ie_empty), .txc_ack(txc_ack),
        .irq_rx(irq_rx), .irq_txc(irq_txc), .irq_empty(irq_empty)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic a, output logic [DATA_W-1:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic data_read(output logic [DATA_W-1:0] v);
        @(negedge clk);
        reg_addr = 1'b0; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rx_push(input logic [DATA_W-1:0] b, input logic ok);
        @(negedge clk);
        rx_byte = b; rx_stop_ok = ok; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset;
        logic [DATA_W-1:0] v;
        peek(1'b1, v); chk("R1 status", v, 8'h20);
        peek(1'b0, v); chk("R1 data", v, 8'h00);
        chk("R1 tx_start", tx_start, 1'b0);
        chk("R10 irq_empty at reset", irq_empty, 1'b1);
    endtask

    task automatic t_single_tx;
        logic [DATA_W-1:0] v;
        bus_write(1'b0, 8'hA5);
        peek(1'b1, v); chk("R2 empty cleared", v[5], 1'b0);
        chk("R3 start pulse", tx_start, 1'b1);
        chk("R3 start byte", tx_byte, 8'hA5);
        @(negedge clk);
        peek(1'b1, v); chk("R3 empty back", v[5], 1'b1);
        chk("R3 single pulse", tx_start, 1'b0);
    endtask

    task automatic t_double_buffer;
        logic [DATA_W-1:0] v;
        bus_write(1'b0, 8'h3C);
        peek(1'b1, v); chk("R4 held empty=0", v[5], 1'b0);
        chk("R4 no start while shifting", tx_start, 1'b0);
        @(negedge clk);
        tx_done = 1'b1;
        #1 chk("R4 relaunch with done", tx_start, 1'b1);
        chk("R4 relaunch byte", tx_byte, 8'h3C);
        @(negedge clk);
        tx_done = 1'b0;
        peek(1'b1, v); chk("R5 no txc with pending", v[6], 1'b0);
        chk("R4 empty after relaunch", v[5], 1'b1);
        @(negedge clk);
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        peek(1'b1, v); chk("R5 txc set", v, 8'h60);
        chk("R10 irq_txc", irq_txc, 1'b1);
    endtask

    task automatic t_txc_clear;
        logic [DATA_W-1:0] v;
        bus_write(1'b1, 8'hBF);
        peek(1'b1, v); chk("R6 write 0 keeps txc, others read-only", v, 8'h60);
        bus_write(1'b1, 8'h40);
        peek(1'b1, v); chk("R6 write 1 clears txc", v, 8'h20);
        bus_write(1'b0, 8'h11);
        @(negedge clk);
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        peek(1'b1, v); chk("R5 txc set again", v[6], 1'b1);
        @(negedge clk);
        txc_ack = 1'b1;
        @(negedge clk);
        txc_ack = 1'b0;
        peek(1'b1, v); chk("R6 ack clears txc", v[6], 1'b0);
        ie_txc = 1'b0; ie_empty = 1'b0;
        #1 chk("R10 irq_empty gated", irq_empty, 1'b0);
        ie_empty = 1'b1;
    endtask

    task automatic t_rx;
        logic [DATA_W-1:0] v;
        rx_push(8'h5A, 1'b1);
        peek(1'b1, v); chk("R7 rxc set fe clear", v, 8'hA0);
        chk("R10 irq_rx", irq_rx, 1'b1);
        data_read(v); chk("R8 read data", v, 8'h5A);
        peek(1'b1, v); chk("R8 rxc cleared", v, 8'h20);
        rx_push(8'hC3, 1'b0);
        peek(1'b1, v); chk("R7 rxc with framing error", v, 8'hB0);
        ie_rx = 1'b0;
        #1 chk("R10 irq_rx gated", irq_rx, 1'b0);
        ie_rx = 1'b1;
        rx_push(8'h77, 1'b1);
        peek(1'b1, v); chk("R9 overrun set", v, 8'hB8);
        peek(1'b0, v); chk("R9 byte discarded", v, 8'hC3);
        data_read(v); chk("R8 read held", v, 8'hC3);
        peek(1'b1, v); chk("R8 overrun cleared", v, 8'h30);
        chk("R11 reserved zero", v[2:0], 3'b000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_tx();
        t_double_buffer();
        t_txc_clear();
        t_rx();
        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule